// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Interrupt Flag Unit

This block holds the alarm settings of a PC-style real-time clock and turns clock events into interrupt status. Software writes BCD alarm values for second, minute and hour, and optionally for day of month and month, through a small register port. Once per second, on a strobe from the timekeeping counters outside the block, the current BCD time is compared against those alarms. An alarm field holding an out-of-range code matches every time value.

Three event flags are kept: periodic (set by an external tick pulse), alarm and update (both set on the once-per-second strobe). The flags latch whatever the state of their enables. A summary bit, which is also the interrupt output, is high while any latched flag has its enable set. Reading the flag register returns the flags and clears them on the next clock.

Top module: `rtc_alarm_irq`

## Requirements
- R1: Register map at `reg_addr`: 0 second alarm, 1 minute alarm, 2 hour alarm, 3 day alarm, 4 month alarm, 5 control, 6 flags. A write to 0..5 on a clock edge is read back on `reg_rdata` from the next cycle. The control register keeps bits 2:0 only and reads 0 in bits 7:3. Address 7 reads 0.
- R2: A `periodic_tick` pulse sets flag bit 0 at the next clock edge, even when control bit 0 (periodic enable) is clear.
- R3: A `sec_tick` pulse sets flag bit 2 (update) at the next clock edge, even when control bit 2 is clear.
- R4: On `sec_tick`, flag bit 1 (alarm) is set at the next clock edge when every non-wildcard alarm field equals its current-time input. If any such field differs, the alarm flag stays clear.
- R5: A second or minute alarm value of 0x60 or above, and an hour alarm value of 0x24 or above (0xFF included), is a wildcard that matches every time value.
- R6: Only bits 5:0 of the day alarm are compared with `now_day`. If those six bits are 0 or above 0x31, the day field is a wildcard.
- R7: A month alarm of 0 or above 0x12 (0xFF included) is a wildcard. The month alarm exists only when the day alarm exists.
- R8: Flag register bit 7 (summary) and `irq` are high exactly while some flag bit 2:0 is set together with the control bit in the same position. Clearing that enable drops `irq` in the cycle after the write.
- R9: A read of address 6 returns the current flags combinationally. All flags, and so the summary bit, clear at the following clock edge. An event that arrives on that same edge is still latched.
- R10: Setting an enable while its flag is already latched raises `irq` in the cycle after the control write.
- R11: After synchronous reset all alarm, control and flag registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the flags clears them) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| sec_tick | input | 1 | Once-per-second update strobe |
| periodic_tick | input | 1 | Periodic event pulse |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench builds the block with both optional alarms present (`HAS_DAY=1`, `HAS_MONTH=1`). With that build, the day-field masking and wildcard codes and the month wildcard codes can be reached alongside the three base fields. A table of alarm and time pairs covers exact matches, single-field mismatches and every wildcard boundary. Directed cases cover enable gating, read-to-clear with an event on the clearing edge, late enabling, and reset in the middle of a run.

// File: rtl/rtc_alarm_pkg.sv
// Package: register addresses, bit positions and per-field compare rules
// for the alarm and interrupt flag unit. Assumes 8-bit BCD fields.
package rtc_alarm_pkg;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int NUM_FIELDS = 5;   // sec, min, hour, day, month

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd6;

    // Event bit positions, shared by control and flag registers
    localparam int B_PER = 0;
    localparam int B_ALM = 1;
    localparam int B_UPD = 2;
    localparam int B_SUM = 7;
    localparam int NUM_EV = 3;

    // Exclusive upper bound: masked alarm values at or above it match all
    function automatic logic [DATA_W-1:0] field_limit(input int idx);
        case (idx)
            0, 1:    return 8'h60;
            2:       return 8'h24;
            3:       return 8'h32;
            default: return 8'h13;
        endcase
    endfunction

    // Bits of the alarm value that take part in the compare
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        return (idx == 3) ? 8'h3F : 8'hFF;
    endfunction

    // Whether a masked value of zero is a wildcard
    function automatic bit field_zero_wild(input int idx);
        return idx >= 3;
    endfunction
endpackage

// File: rtl/rtc_alarm_field.sv
// Compares one BCD alarm field with one current-time field.
// Assumes the current-time input is a legal BCD value for the field.
module rtc_alarm_field #(
    parameter int              W         = 8,
    parameter logic [W-1:0]    MASK      = '1,
    parameter logic [W-1:0]    LIMIT     = '1,
    parameter bit              ZERO_WILD = 1'b0
) (
    input  logic [W-1:0] alarm_val,
    input  logic [W-1:0] now_val,
    output logic         hit
);
    logic [W-1:0] masked;
    logic         wild;

    // Decide wildcard status and equality for this field
    always_comb begin
        masked = alarm_val & MASK;
        wild   = (masked >= LIMIT) || (ZERO_WILD && (masked == '0));
        hit    = wild || (masked == now_val);
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Combines per-field compares into one alarm hit. The optional day field,
// and the month field (which needs the day field), are picked by parameters.
// A field that is left out always counts as matching.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter bit HAS_DAY   = 1'b1,
    parameter bit HAS_MONTH = 1'b1
) (
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_regs,
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] now_time,
    output logic                              all_hit
);
    logic [NUM_FIELDS-1:0] field_hit;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam bit PRESENT = (i < 3) || (i == 3 && HAS_DAY) ||
                                 (i == 4 && HAS_DAY && HAS_MONTH);
        if (PRESENT) begin : g_cmp
            rtc_alarm_field #(
                .W         (DATA_W),
                .MASK      (field_mask(i)),
                .LIMIT     (field_limit(i)),
                .ZERO_WILD (field_zero_wild(i))
            ) u_cmp (
                .alarm_val (alarm_regs[i]),
                .now_val   (now_time[i]),
                .hit       (field_hit[i])
            );
        end else begin : g_absent
            assign field_hit[i] = 1'b1;
        end
    end

    // Alarm matches only when every field matches
    assign all_hit = &field_hit;
endmodule

// File: rtl/rtc_irq_flags.sv
// Event flag store and summary logic. Flags latch whatever the enables say.
// A read-clear empties them at the next edge, and an event on that same edge
// wins over the clear.
module rtc_irq_flags
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periodic_tick,
    input  logic              sec_tick,
    input  logic              alarm_hit,
    input  logic              rd_clr,
    input  logic [NUM_EV-1:0] enables,
    output logic [NUM_EV-1:0] flags_q,
    output logic              summary
);
    logic [NUM_EV-1:0] events;

    // Collect this cycle's events into flag positions
    always_comb begin
        events        = '0;
        events[B_PER] = periodic_tick;
        events[B_ALM] = sec_tick & alarm_hit;
        events[B_UPD] = sec_tick;
    end

    // Latch events; a read-clear empties the flags unless a new event arrives
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd_clr ? '0 : flags_q) | events;
    end

    // Summary is high while any latched flag is enabled
    assign summary = |(flags_q & enables);

    a_r2_periodic_latch: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_tick |=> flags_q[B_PER]);
    a_r3_update_latch: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> flags_q[B_UPD]);
    a_r4_alarm_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && alarm_hit) |=> flags_q[B_ALM]);
    a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !sec_tick && !periodic_tick) |=> (flags_q == '0));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !sec_tick && !periodic_tick) |=> $stable(flags_q));
endmodule

// File: rtl/rtc_alarm_irq.sv
// Alarm and interrupt flag unit of a real-time clock. It holds the alarm and
// control registers, decodes the register port, and drives irq from the
// summary. Time counting is outside: BCD time arrives together with sec_tick.
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter bit HAS_DAY   = 1'b1,
    parameter bit HAS_MONTH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] now_sec,
    input  logic [DATA_W-1:0] now_min,
    input  logic [DATA_W-1:0] now_hour,
    input  logic [DATA_W-1:0] now_day,
    input  logic [DATA_W-1:0] now_mon,
    input  logic              sec_tick,
    input  logic              periodic_tick,
    output logic              irq
);
    localparam bit MON_OK = HAS_DAY && HAS_MONTH;

    logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_q;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] now_time;
    logic [NUM_EV-1:0]                 ctrl_q;
    logic [NUM_EV-1:0]                 flags_q;
    logic                              summary;
    logic                              alarm_hit;
    logic                              rd_clr;

    assign now_time = {now_mon, now_day, now_hour, now_min, now_sec};
    assign rd_clr   = reg_rd && (reg_addr == A_FLAGS);

    // Alarm field registers; absent optional fields ignore writes
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alarm
        localparam bit PRESENT = (i < 3) || (i == 3 && HAS_DAY) ||
                                 (i == 4 && MON_OK);
        if (PRESENT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) alarm_q[i] <= '0;
                else if (reg_wr && reg_addr == ADDR_W'(i)) alarm_q[i] <= reg_wdata;
            end
        end else begin : g_none
            assign alarm_q[i] = '0;
        end
    end

    // Control register: the three event enables
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[NUM_EV-1:0];
    end

    rtc_alarm_match #(.HAS_DAY(HAS_DAY), .HAS_MONTH(HAS_MONTH)) u_match (
        .alarm_regs (alarm_q),
        .now_time   (now_time),
        .all_hit    (alarm_hit)
    );

    rtc_irq_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .periodic_tick (periodic_tick),
        .sec_tick      (sec_tick),
        .alarm_hit     (alarm_hit),
        .rd_clr        (rd_clr),
        .enables       (ctrl_q),
        .flags_q       (flags_q),
        .summary       (summary)
    );

    // Read mux: alarms, control, and flags with the summary in bit 7
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < ADDR_W'(NUM_FIELDS)) begin
            reg_rdata = alarm_q[reg_addr];
        end else if (reg_addr == A_CTRL) begin
            reg_rdata[NUM_EV-1:0] = ctrl_q;
        end else if (reg_addr == A_FLAGS) begin
            reg_rdata[NUM_EV-1:0] = flags_q;
            reg_rdata[B_SUM]      = summary;
        end
    end

    assign irq = summary;

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_q != '0) && (flags_q != '0));
    a_r8_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[NUM_EV-1:0] == '0) |=> !irq);
    a_r10_late_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !rd_clr &&
         ((reg_wdata[NUM_EV-1:0] & flags_q) != '0)) |=> irq);
endmodule

// File: tb/rtc_alarm_irq_bench.sv
`timescale 1ns/1ps
// Bench for rtc_alarm_irq: a table of alarm/time vectors, then directed cases.
module rtc_alarm_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0, now_mon = '0;
    logic       sec_tick = 1'b0, periodic_tick = 1'b0;
    logic       irq;
    int         total = 0, bad = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_irq #(.HAS_DAY(1'b1), .HAS_MONTH(1'b1)) u_rtc_alarm_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_day(now_day), .now_mon(now_mon), .sec_tick(sec_tick),
        .periodic_tick(periodic_tick), .irq(irq));

    // alarm s,m,h,d,mo | now s,m,h,d,mo | expected alarm flag
    localparam int NV = 12;
    localparam logic [80:0] VEC [NV] = '{
        {8'h30,8'h15,8'h08,8'h12,8'h05, 8'h30,8'h15,8'h08,8'h12,8'h05, 1'b1},
        {8'h30,8'h15,8'h08,8'h12,8'h05, 8'h31,8'h15,8'h08,8'h12,8'h05, 1'b0},
        {8'hFF,8'hFF,8'hFF,8'h00,8'h00, 8'h47,8'h59,8'h23,8'h31,8'h12, 1'b1},
        {8'h60,8'h15,8'h08,8'h00,8'h00, 8'h22,8'h15,8'h08,8'h01,8'h01, 1'b1},
        {8'h00,8'h10,8'h24,8'h00,8'h00, 8'h00,8'h11,8'h05,8'h01,8'h01, 1'b0},
        {8'h00,8'h10,8'h24,8'h00,8'h00, 8'h00,8'h10,8'h05,8'h01,8'h01, 1'b1},
        {8'h00,8'h00,8'h00,8'hC7,8'h00, 8'h00,8'h00,8'h00,8'h07,8'h03, 1'b1},
        {8'h00,8'h00,8'h00,8'h32,8'h00, 8'h00,8'h00,8'h00,8'h15,8'h03, 1'b1},
        {8'h00,8'h00,8'h00,8'h07,8'h00, 8'h00,8'h00,8'h00,8'h08,8'h03, 1'b0},
        {8'h00,8'h00,8'h00,8'h00,8'h13, 8'h00,8'h00,8'h00,8'h01,8'h09, 1'b1},
        {8'h00,8'h00,8'h00,8'h00,8'h09, 8'h00,8'h00,8'h00,8'h01,8'h10, 1'b0},
        {8'hFF,8'hFF,8'hFF,8'hFF,8'hFF, 8'h12,8'h34,8'h11,8'h22,8'h04, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0;
    endtask

    // Read with optional clear side effect; data sampled mid-cycle
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(posedge clk); @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse_sec();
        @(negedge clk); sec_tick = 1'b1; @(posedge clk); @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic pulse_per();
        @(negedge clk); periodic_tick = 1'b1; @(posedge clk); @(negedge clk); periodic_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R11 reset state
        rd(3'd0, v); check("R11 sec alarm reset", v, 8'h00);
        rd(3'd5, v); check("R11 ctrl reset", v, 8'h00);
        rd(3'd6, v); check("R11 flags reset", v, 8'h00);
        check("R11 irq reset", {7'd0, irq}, 8'h00);

        // R4 R5 R6 R7 table with enables off
        for (int i = 0; i < NV; i++) begin
            for (int f = 0; f < 5; f++) wr(3'(f), VEC[i][80 - 8*f -: 8]);
            now_sec = VEC[i][40:33]; now_min = VEC[i][32:25]; now_hour = VEC[i][24:17];
            now_day = VEC[i][16:9]; now_mon = VEC[i][8:1];
            pulse_sec();
            check("R3 R4 table irq off", {7'd0, irq}, 8'h00);
            rd(3'd6, v);
            check($sformatf("R4 R5 R6 R7 vector %0d", i), v, {5'd0, 1'b1, VEC[i][0], 1'b0});
        end

        // R1 readback
        wr(3'd1, 8'h42); rd(3'd1, v); check("R1 min alarm readback", v, 8'h42);
        wr(3'd4, 8'h11); rd(3'd4, v); check("R1 month alarm readback", v, 8'h11);
        wr(3'd5, 8'hFF); rd(3'd5, v); check("R1 ctrl keeps low bits", v, 8'h07);
        rd(3'd7, v); check("R1 unused address", v, 8'h00);
        wr(3'd5, 8'h00);

        // R2 periodic latches with enable clear, R9 read clears
        pulse_per();
        check("R2 irq stays low", {7'd0, irq}, 8'h00);
        rd(3'd6, v); check("R2 periodic flag latched", v, 8'h01);
        rd(3'd6, v); check("R9 flags cleared after read", v, 8'h00);

        // R10 late enable, then R8 summary and read-clear drops irq
        pulse_per();
        wr(3'd5, 8'h01);
        check("R10 irq after enable", {7'd0, irq}, 8'h01);
        rd(3'd6, v); check("R8 summary bit set", v, 8'h81);
        check("R9 irq low after clear", {7'd0, irq}, 8'h00);

        // R8 dropping the enable deasserts irq
        pulse_per();
        check("R8 irq with enable", {7'd0, irq}, 8'h01);
        wr(3'd5, 8'h00);
        check("R8 irq after enable drop", {7'd0, irq}, 8'h00);
        rd(3'd6, v); check("R8 flag kept, no summary", v, 8'h01);

        // R9 event on the clearing edge is kept
        pulse_per();
        @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd6; sec_tick = 1'b1;
        @(posedge clk); @(negedge clk); reg_rd = 1'b0; sec_tick = 1'b0;
        rd(3'd6, v); check("R9 event on clear edge", v, 8'h04);

        // R4 alarm flag drives irq when enabled
        wr(3'd0, 8'h05); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
        now_sec = 8'h05; wr(3'd5, 8'h02);
        pulse_sec();
        check("R4 alarm irq", {7'd0, irq}, 8'h01);
        rd(3'd6, v); check("R4 alarm flags", v, 8'h86);

        // R11 reset mid-run
        pulse_per();
        @(negedge clk); rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
        rd(3'd6, v); check("R11 flags after reset", v, 8'h00);
        rd(3'd0, v); check("R11 alarm after reset", v, 8'h00);
        rd(3'd5, v); check("R11 ctrl after reset", v, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule